// File: doc/BRIEF.md
# Two-Master Bus Sharing Arbiter

This block lets two controllers share one external memory bus over a three-wire handshake: a hold request, a hold acknowledge and a bus request. One controller is the master and owns the bus after reset. The other is the slave, which asks for the bus when it has work and gives it back when it is done. The same block can take either role. The role decides the direction of the pins. In slave mode the acknowledge pin becomes an input and the hold pin becomes an output, so two instances can be wired pin to pin with no extra logic.

On the local side the block talks to the bus cycle generator. It drives a `grant` that allows new cycles to start and a `bus_drive` that enables the external bus drivers. It reads `cyc_idle`, which says that no cycle is in flight, and `acc_pend`, which says that an internal access is waiting. The bus is handed over only between cycles. Before that, `grant` is withdrawn while the current cycle drains.

While `arb_en` is low the arbiter is passive: it drives none of the three pins and the local bus works normally. All pin signals are active high. The three pin inputs pass through a synchroniser of `SYNC_STAGES` flops before any state machine sees them. With the default depth, a pin change reaches the outputs three clock edges after it is presented.

Top module: `bus_share_arb`

## Requirements
- R1: After reset and whenever `arb_en` is low, the outputs are grant=1 and bus_drive=1, with ack_out, hold_out and req_out at 0 and all three output enables at 0. Pin inputs are ignored in this state.
- R2: The role is sampled from `slave_sel` (0 = master, 1 = slave) only while `arb_en` is low. A change of `slave_sel` while enabled has no effect. Reset selects master.
- R3: When enabled as master, ack_oe=1, req_oe=1 and hold_oe=0. When enabled as slave, hold_oe=1 and ack_oe=req_oe=0.
- R4: As master, a raised `hold_in` drops `grant` three edges later while `bus_drive` stays 1. If `hold_in` falls before the hand-over, grant returns three edges after the fall.
- R5: As master, the hand-over happens only on an edge where `cyc_idle` is 1. On the edge after that, ack_out=1, bus_drive=0 and grant=0.
- R6: As master in the held state, a falling `hold_in` clears ack_out and restores grant and bus_drive three edges after the fall.
- R7: As master, req_out is 1 only while ack_out is 1 and `acc_pend` is 1.
- R8: Once enabled as slave, the block starts with grant=0 and bus_drive=0 one edge after enable. hold_out rises one edge after `acc_pend` is seen.
- R9: As slave, grant and bus_drive become 1 only after hold_out is raised and `ack_in` has been high for three edges.
- R10: As slave owning the bus, either `acc_pend` low or `req_in` high withdraws grant first. hold_out and bus_drive then fall on the edge after `cyc_idle` is seen.
- R11: As slave, after it releases the bus, no new hold request is made until `ack_in` has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | Enables arbitration and pin control |
| slave_sel | input | 1 | Role select, sampled while disabled (1 = slave) |
| cyc_idle | input | 1 | Bus cycle generator has no cycle in flight |
| acc_pend | input | 1 | An internal access is waiting for the bus |
| grant | output | 1 | New bus cycles may start |
| bus_drive | output | 1 | Enable for the external bus drivers |
| hold_in | input | 1 | Hold request pin, input side |
| hold_out | output | 1 | Hold request pin, output side |
| hold_oe | output | 1 | Hold request pin output enable |
| ack_in | input | 1 | Hold acknowledge pin, input side |
| ack_out | output | 1 | Hold acknowledge pin, output side |
| ack_oe | output | 1 | Hold acknowledge pin output enable |
| req_in | input | 1 | Bus request pin, input side |
| req_out | output | 1 | Bus request pin, output side |
| req_oe | output | 1 | Bus request pin output enable |

## Verification
The properties assume that the bus cycle generator obeys `grant`. When `grant` is low it starts no new cycle, so `cyc_idle` taken on an edge after grant fell really means that the bus is quiet. The properties also assume that `slave_sel` does not move in the cycle where `arb_en` rises. The stimulus changes inputs only a short time after a rising edge. It holds each input pattern for several edges, so the synchronisers always settle. It raises `cyc_idle` only while no cycle would be running, and it sets the role during a disabled interval before enabling.

// File: rtl/bus_share_pkg.sv
package bus_share_pkg;

  typedef enum logic [1:0] {
    M_OWN  = 2'd0,
    M_STOP = 2'd1,
    M_HELD = 2'd2
  } mst_state_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_REQ     = 3'd1,
    S_OWN     = 3'd2,
    S_DRAIN   = 3'd3,
    S_WAITACK = 3'd4
  } slv_state_e;

  typedef struct packed {
    logic grant;
    logic bus_drive;
    logic ack_out;
    logic hold_out;
    logic req_out;
  } pin_out_t;

  localparam pin_out_t PIN_DEFAULT = '{grant: 1'b1, bus_drive: 1'b1,
                                       ack_out: 1'b0, hold_out: 1'b0,
                                       req_out: 1'b0};

endpackage

// File: rtl/bus_share_sync.sv
module bus_share_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        stg[i] <= stg[i-1];
      end
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bus_share_master.sv
module bus_share_master
  import bus_share_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     hold_s,
  input  logic     cyc_idle,
  input  logic     acc_pend,
  output pin_out_t nxt
);

  mst_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      M_OWN:  if (hold_s) st_d = M_STOP;
      M_STOP: begin
        if (!hold_s)       st_d = M_OWN;
        else if (cyc_idle) st_d = M_HELD;
      end
      M_HELD: if (!hold_s) st_d = M_OWN;
      default: st_d = M_OWN;
    endcase
    if (!run) st_d = M_OWN;
  end

  always_comb begin
    nxt = PIN_DEFAULT;
    unique case (st_d)
      M_STOP: nxt.grant = 1'b0;
      M_HELD: begin
        nxt.grant     = 1'b0;
        nxt.bus_drive = 1'b0;
        nxt.ack_out   = 1'b1;
        nxt.req_out   = acc_pend;
      end
      default: nxt = PIN_DEFAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= M_OWN;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/bus_share_slave.sv
module bus_share_slave
  import bus_share_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     ack_s,
  input  logic     req_s,
  input  logic     cyc_idle,
  input  logic     acc_pend,
  output pin_out_t nxt
);

  slv_state_e st_q, st_d;
  logic       want_bus;

  assign want_bus = acc_pend && !req_s;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (acc_pend) st_d = S_REQ;
      S_REQ:     if (ack_s)    st_d = S_OWN;
      S_OWN:     if (!want_bus) st_d = S_DRAIN;
      S_DRAIN: begin
        if (want_bus)      st_d = S_OWN;
        else if (cyc_idle) st_d = S_WAITACK;
      end
      S_WAITACK: if (!ack_s) st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
    if (!run) st_d = S_IDLE;
  end

  always_comb begin
    nxt = '0;
    unique case (st_d)
      S_REQ:   nxt.hold_out = 1'b1;
      S_OWN: begin
        nxt.grant     = 1'b1;
        nxt.bus_drive = 1'b1;
        nxt.hold_out  = 1'b1;
      end
      S_DRAIN: begin
        nxt.bus_drive = 1'b1;
        nxt.hold_out  = 1'b1;
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb
  import bus_share_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arb_en,
  input  logic slave_sel,
  input  logic cyc_idle,
  input  logic acc_pend,
  output logic grant,
  output logic bus_drive,
  input  logic hold_in,
  output logic hold_out,
  output logic hold_oe,
  input  logic ack_in,
  output logic ack_out,
  output logic ack_oe,
  input  logic req_in,
  output logic req_out,
  output logic req_oe
);

  localparam int PIN_IN_W = 3;

  logic                role_q;
  logic [PIN_IN_W-1:0] pins_s;
  logic                hold_s, ack_s, req_s;
  pin_out_t            mst_nxt, slv_nxt, out_q;
  logic [2:0]          oe_q;

  always_ff @(posedge clk) begin
    if (rst)          role_q <= 1'b0;
    else if (!arb_en) role_q <= slave_sel;
  end

  bus_share_sync #(.WIDTH(PIN_IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_in, ack_in, req_in}),
    .q   (pins_s)
  );
  assign {hold_s, ack_s, req_s} = pins_s;

  bus_share_master i_master (
    .clk      (clk),
    .rst      (rst),
    .run      (arb_en && !role_q),
    .hold_s   (hold_s),
    .cyc_idle (cyc_idle),
    .acc_pend (acc_pend),
    .nxt      (mst_nxt)
  );

  bus_share_slave i_slave (
    .clk      (clk),
    .rst      (rst),
    .run      (arb_en && role_q),
    .ack_s    (ack_s),
    .req_s    (req_s),
    .cyc_idle (cyc_idle),
    .acc_pend (acc_pend),
    .nxt      (slv_nxt)
  );

  // oe_q bits: {ack, hold, req}
  always_ff @(posedge clk) begin
    if (rst || !arb_en) begin
      out_q <= PIN_DEFAULT;
      oe_q  <= 3'b000;
    end else if (role_q) begin
      out_q <= slv_nxt;
      oe_q  <= 3'b010;
    end else begin
      out_q <= mst_nxt;
      oe_q  <= 3'b101;
    end
  end

  assign grant     = out_q.grant;
  assign bus_drive = out_q.bus_drive;
  assign ack_out   = out_q.ack_out;
  assign hold_out  = out_q.hold_out;
  assign req_out   = out_q.req_out;
  assign {ack_oe, hold_oe, req_oe} = oe_q;

endmodule

// File: rtl/bus_share_arb_chk.sv
module bus_share_arb_chk (
  input logic clk,
  input logic rst,
  input logic arb_en,
  input logic cyc_idle,
  input logic acc_pend,
  input logic grant,
  input logic bus_drive,
  input logic hold_out,
  input logic hold_oe,
  input logic ack_out,
  input logic ack_oe,
  input logic req_out,
  input logic req_oe
);

  a_r1_passive: assert property (@(posedge clk) disable iff (rst)
    !arb_en |=> (grant && bus_drive && !ack_out && !hold_out && !req_out
                 && !ack_oe && !hold_oe && !req_oe));

  a_r3_dir_excl: assert property (@(posedge clk) disable iff (rst)
    hold_oe |-> (!ack_oe && !req_oe));

  a_r3_master_pair: assert property (@(posedge clk) disable iff (rst)
    ack_oe |-> req_oe);

  a_r4_stall_held: assert property (@(posedge clk) disable iff (rst)
    ack_out |-> !grant);

  a_r5_ack_on_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> ($past(cyc_idle) && !bus_drive));

  a_r5_float_on_idle: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_drive) && ($past(hold_oe) || $past(ack_oe))) |-> $past(cyc_idle));

  a_r7_req_needs_ack: assert property (@(posedge clk) disable iff (rst)
    req_out |-> ack_out);

  a_r8_hold_after_pend: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_out) |-> $past(acc_pend));

  a_r9_grant_driven: assert property (@(posedge clk) disable iff (rst)
    grant |-> bus_drive);

  a_r9_slave_owns: assert property (@(posedge clk) disable iff (rst)
    (hold_oe && bus_drive) |-> hold_out);

endmodule

bind bus_share_arb bus_share_arb_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .arb_en    (arb_en),
  .cyc_idle  (cyc_idle),
  .acc_pend  (acc_pend),
  .grant     (grant),
  .bus_drive (bus_drive),
  .hold_out  (hold_out),
  .hold_oe   (hold_oe),
  .ack_out   (ack_out),
  .ack_oe    (ack_oe),
  .req_out   (req_out),
  .req_oe    (req_oe)
);

// File: tb/test_bus_share_arb.sv
module test_bus_share_arb;

  logic clk = 1'b0;
  logic rst;
  logic arb_en, slave_sel, cyc_idle, acc_pend;
  logic hold_in, ack_in, req_in;
  logic grant, bus_drive, hold_out, hold_oe, ack_out, ack_oe, req_out, req_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_share_arb i_bus_share_arb (
    .clk       (clk),
    .rst       (rst),
    .arb_en    (arb_en),
    .slave_sel (slave_sel),
    .cyc_idle  (cyc_idle),
    .acc_pend  (acc_pend),
    .grant     (grant),
    .bus_drive (bus_drive),
    .hold_in   (hold_in),
    .hold_out  (hold_out),
    .hold_oe   (hold_oe),
    .ack_in    (ack_in),
    .ack_out   (ack_out),
    .ack_oe    (ack_oe),
    .req_in    (req_in),
    .req_out   (req_out),
    .req_oe    (req_oe)
  );

  // input {en, slv, hold, ack, req, idle, pend}
  // expect {grant, drive, ack_o, hold_o, req_o, ack_oe, hold_oe, req_oe}
  localparam int NV = 20;
  localparam logic [14:0] VEC [NV] = '{
    {7'b0000010, 8'b11000000},
    {7'b1000010, 8'b11000101},
    {7'b1010000, 8'b01000101},
    {7'b1010010, 8'b00100101},
    {7'b1010011, 8'b00101101},
    {7'b1000011, 8'b11000101},
    {7'b0010011, 8'b11000000},
    {7'b0100010, 8'b11000000},
    {7'b1100010, 8'b00000010},
    {7'b1100011, 8'b00010010},
    {7'b1101011, 8'b11010010},
    {7'b1001011, 8'b11010010},
    {7'b1001000, 8'b01010010},
    {7'b1001010, 8'b00000010},
    {7'b1001011, 8'b00000010},
    {7'b1000011, 8'b00010010},
    {7'b1001011, 8'b11010010},
    {7'b1001111, 8'b00000010},
    {7'b1000000, 8'b00000010},
    {7'b0000010, 8'b11000000}
  };

  function automatic string vtag(int i);
    case (i)
      0, 6:       return "R1";
      1:          return "R3";
      2:          return "R4";
      3:          return "R5";
      4:          return "R7";
      5:          return "R6";
      7, 11, 19:  return "R2";
      8, 9:       return "R8";
      10, 16:     return "R9";
      12, 13, 17: return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic drv(input logic [6:0] v);
    {arb_en, slave_sel, hold_in, ack_in, req_in, cyc_idle, acc_pend} = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] outs();
    return {grant, bus_drive, ack_out, hold_out, req_out, ack_oe, hold_oe, req_oe};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drv(7'b1010011);
    step(3);
    chk("R1 reset", outs(), 8'b11000000);
    rst = 1'b0;
    drv(7'b0000010);
    step(2);

    for (int i = 0; i < NV; i++) begin
      drv(VEC[i][14:8]);
      step(6);
      chk(vtag(i), outs(), VEC[i][7:0]);
    end

    // master hold latency, idle gating and release
    rst = 1'b1;
    drv(7'b1000010);
    step(2);
    rst = 1'b0;
    step(3);
    drv(7'b1010000);
    step(2);
    chk1("R4 grant before sync", grant, 1'b1);
    step(1);
    chk("R4 grant withdrawn", outs(), 8'b01000101);
    step(3);
    chk1("R5 no ack while busy", ack_out, 1'b0);
    drv(7'b1010010);
    step(1);
    chk("R5 hand-over", outs(), 8'b00100101);
    drv(7'b1000010);
    step(2);
    chk1("R6 ack held during sync", ack_out, 1'b1);
    step(1);
    chk("R6 bus reclaimed", outs(), 8'b11000101);

    // master abort before hand-over
    drv(7'b1010000);
    step(3);
    chk1("R4 stop", grant, 1'b0);
    drv(7'b1000000);
    step(3);
    chk("R4 abort restores grant", outs(), 8'b11000101);

    // slave latency
    drv(7'b0100010);
    step(2);
    drv(7'b1100010);
    step(1);
    chk("R8 slave starts floated", outs(), 8'b00000010);
    drv(7'b1100011);
    step(1);
    chk1("R8 hold one edge after pend", hold_out, 1'b1);
    drv(7'b1101011);
    step(2);
    chk1("R9 no grant before ack sync", grant, 1'b0);
    step(1);
    chk("R9 slave owns bus", outs(), 8'b11010010);
    drv(7'b1101010);
    step(1);
    chk("R10 grant first", outs(), 8'b01010010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule